// File: doc/BRIEF.md
# Hardware S-Record Text Loader Parser

This block reads an ASCII character stream, one character per strobe, and decodes it as S-record text with no processor involved. A serial receiver usually supplies the stream. Records that carry a 32-bit load address are turned into byte-wide memory writes while they are parsed. Each write has an address, a data byte and a one-cycle valid pulse. The addresses run upward from the record's load address, one per data byte.

A loading flag shows when a load is under way. A system can use it to hold a processor in reset and to steer a memory mux to the loader. The flag rises on the first data record and falls on the end record. Each data record's checksum is verified. Any malformed text stops the parser and latches an error flag, together with the number of the text line that failed. The parser stays stopped until reset.

Top module: `srec_loader_parser`

## Requirements
- R1: The parser advances only in cycles where `char_valid` is high. In any cycle after one without a strobe, `wr_valid` is low and `loading` and `err` are unchanged.
- R2: While waiting for a record, every character other than 'S' (0x53) is ignored. It causes no write, no error and no change to `loading`.
- R3: In a data record ('S' then '3'), the count field is followed by eight hex characters giving a 32-bit address, most significant first. Data byte i is written to address+i (modulo 2^32). Its `wr_valid` pulse lasts one cycle and is visible after the clock edge that takes the low nibble character of that byte.
- R4: The hex digits are '0'-'9' (0x30-0x39) and uppercase 'A'-'F' (0x41-0x46), worth 0-15. Any other character in a hex field, lowercase letters included, is an error.
- R5: `loading` goes high at the edge that takes the '3' of a data record. It goes low at the edge that takes the '7' of an end record.
- R6: The count field is two hex characters. It gives the number of bytes that follow: address, data and checksum. A count below 5 is an error. The number of data bytes is count-5.
- R7: The checksum byte must equal the bitwise inverse of the low 8 bits of the sum of the count byte, the four address bytes and the data bytes. A mismatch raises `err`.
- R8: `err` is sticky until reset. Once it is raised, `err_line` holds the line number where the fault occurred, no further writes are issued and all input is ignored.
- R9: The line number starts at 1 after reset and increases by 1 for each line feed (0x0A). After the checksum, carriage returns (0x0D) are skipped. Any other character before the line feed is an error.
- R10: If the type character is a digit other than '3' or '7', the record is skipped up to its line feed without writes or errors. A type character that is not a digit is an error.
- R11: After reset, `wr_valid`, `loading` and `err` are 0 and `err_line` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_valid | input | 1 | A new character is present on `char_in` this cycle |
| char_in | input | 8 | ASCII character |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data byte |
| loading | output | 1 | A load is in progress |
| err | output | 1 | Sticky error flag |
| err_line | output | LINE_W | Line number of the first error |

## Verification
A wrong parse state shows up at the next strobed character. It appears as a write where none belongs, a missing write, a write at a shifted address, or an early or spurious `err`. Every data character is checked in the cycle right after it is taken. A wrong checksum accumulator shows only at the end of its record, as a false or missed `err`. A wrong line count shows only in `err_line` when an error is latched. For this reason the error cases are placed after different numbers of line feeds.

// File: rtl/srec_pkg.sv
// Shared parse-state type and character codes for the S-record loader.
// Assumes 8-bit ASCII input.
package srec_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_TYPE, ST_CNT_HI, ST_CNT_LO, ST_ADDR, ST_DAT_HI,
        ST_DAT_LO, ST_CHK_HI, ST_CHK_LO, ST_EOL, ST_SKIP, ST_ERR
    } pstate_t;

    localparam logic [7:0] CH_S  = 8'h53;
    localparam logic [7:0] CH_0  = 8'h30;
    localparam logic [7:0] CH_3  = 8'h33;
    localparam logic [7:0] CH_7  = 8'h37;
    localparam logic [7:0] CH_9  = 8'h39;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_CR = 8'h0D;
endpackage

// File: rtl/srec_hex_decode.sv
// Combinational ASCII hex digit decoder.
// Accepts '0'-'9' and uppercase 'A'-'F' only; flags anything else.
module srec_hex_decode (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] val
);
    // Decode the digit value and its validity.
    always_comb begin
        is_hex = 1'b0;
        val    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            val    = ch[3:0];
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            val    = ch[3:0] + 4'd9;
        end
    end
endmodule

// File: rtl/srec_csum_acc.sv
// Modulo-256 byte accumulator for the record checksum.
// Pure datapath: the value is defined only after the first clear.
module srec_csum_acc (
    input  logic       clk,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] add_byte,
    output logic [7:0] sum
);
    logic [7:0] sum_q;

    // Clear at record start, add each completed byte.
    always_ff @(posedge clk) begin
        if (clr)      sum_q <= 8'h00;
        else if (add) sum_q <= sum_q + add_byte;
    end

    assign sum = sum_q;
endmodule

// File: rtl/srec_line_ctr.sv
// Text line counter: starts at 1 and steps on each enabled line feed.
// Assumes the caller gates inc with the line-feed decode.
module srec_line_ctr #(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [LINE_W-1:0] line
);
    logic [LINE_W-1:0] line_q;

    // Count line feeds from a reset value of one.
    always_ff @(posedge clk) begin
        if (!rst_n)   line_q <= LINE_W'(1);
        else if (inc) line_q <= line_q + LINE_W'(1);
    end

    assign line = line_q;

    // R9: every counted line feed moves the line number.
    a_r9_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> line != $past(line));
endmodule

// File: rtl/srec_loader_parser.sv
// S-record text parser emitting byte write transactions.
// Takes one character per char_valid cycle. Handles data records carrying
// a 32-bit address and the matching end record; skips other digit types.
// Assumes ADDR_W is a multiple of 8. Stops on the first error until reset.
module srec_loader_parser
    import srec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [7:0]        char_in,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              loading,
    output logic              err,
    output logic [LINE_W-1:0] err_line
);
    localparam int         ADDR_NIB  = ADDR_W / 4;
    localparam int         NIB_W     = $clog2(ADDR_NIB);
    localparam logic [7:0] MIN_COUNT = 8'(ADDR_NIB / 2 + 1);
    localparam logic [NIB_W-1:0] LAST_NIB = NIB_W'(ADDR_NIB - 1);

    pstate_t           st_q, st_d;
    logic [3:0]        nib_hi_q, nib_hi_d;
    logic [7:0]        cnt_q, cnt_d;
    logic [NIB_W-1:0]  nib_idx_q, nib_idx_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_data_q;
    logic              wr_valid_q, loading_q, err_q;
    logic [LINE_W-1:0] err_line_q;

    logic              is_hex;
    logic [3:0]        nib;
    logic [7:0]        byte_v;
    logic [7:0]        csum_sum;
    logic [LINE_W-1:0] line_cur;
    logic              wr_fire, csum_clr, csum_add, load_set, load_clr, bad;
    logic              lf_seen;

    srec_hex_decode u_hex (
        .ch     (char_in),
        .is_hex (is_hex),
        .val    (nib)
    );

    assign byte_v = {nib_hi_q, nib};

    srec_csum_acc u_csum (
        .clk      (clk),
        .clr      (csum_clr),
        .add      (csum_add),
        .add_byte (byte_v),
        .sum      (csum_sum)
    );

    assign lf_seen = char_valid && (char_in == CH_LF) && (st_q != ST_ERR);

    srec_line_ctr #(.LINE_W(LINE_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (lf_seen),
        .line  (line_cur)
    );

    // Next-state and datapath control, evaluated only on a strobed character.
    always_comb begin
        st_d      = st_q;
        nib_hi_d  = nib_hi_q;
        cnt_d     = cnt_q;
        nib_idx_d = nib_idx_q;
        addr_d    = addr_q;
        wr_fire   = 1'b0;
        csum_clr  = 1'b0;
        csum_add  = 1'b0;
        load_set  = 1'b0;
        load_clr  = 1'b0;
        bad       = 1'b0;
        if (char_valid) begin
            unique case (st_q)
                ST_IDLE: if (char_in == CH_S) st_d = ST_TYPE;
                ST_TYPE: begin
                    if (char_in == CH_3) begin
                        st_d     = ST_CNT_HI;
                        load_set = 1'b1;
                        csum_clr = 1'b1;
                    end else if (char_in == CH_7) begin
                        st_d     = ST_SKIP;
                        load_clr = 1'b1;
                    end else if (char_in >= CH_0 && char_in <= CH_9) begin
                        st_d = ST_SKIP;
                    end else begin
                        bad = 1'b1;
                    end
                end
                ST_CNT_HI: begin
                    if (!is_hex) bad = 1'b1;
                    else begin
                        nib_hi_d = nib;
                        st_d     = ST_CNT_LO;
                    end
                end
                ST_CNT_LO: begin
                    if (!is_hex || byte_v < MIN_COUNT) bad = 1'b1;
                    else begin
                        cnt_d     = byte_v - MIN_COUNT;
                        csum_add  = 1'b1;
                        nib_idx_d = '0;
                        st_d      = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (!is_hex) bad = 1'b1;
                    else begin
                        addr_d    = {addr_q[ADDR_W-5:0], nib};
                        nib_idx_d = nib_idx_q + NIB_W'(1);
                        if (nib_idx_q[0]) csum_add = 1'b1;
                        else              nib_hi_d = nib;
                        if (nib_idx_q == LAST_NIB)
                            st_d = (cnt_q == 8'd0) ? ST_CHK_HI : ST_DAT_HI;
                    end
                end
                ST_DAT_HI: begin
                    if (!is_hex) bad = 1'b1;
                    else begin
                        nib_hi_d = nib;
                        st_d     = ST_DAT_LO;
                    end
                end
                ST_DAT_LO: begin
                    if (!is_hex) bad = 1'b1;
                    else begin
                        wr_fire  = 1'b1;
                        csum_add = 1'b1;
                        addr_d   = addr_q + ADDR_W'(1);
                        cnt_d    = cnt_q - 8'd1;
                        st_d     = (cnt_q == 8'd1) ? ST_CHK_HI : ST_DAT_HI;
                    end
                end
                ST_CHK_HI: begin
                    if (!is_hex) bad = 1'b1;
                    else begin
                        nib_hi_d = nib;
                        st_d     = ST_CHK_LO;
                    end
                end
                ST_CHK_LO: begin
                    if (!is_hex || byte_v != ~csum_sum) bad = 1'b1;
                    else st_d = ST_EOL;
                end
                ST_EOL: begin
                    if (char_in == CH_LF)      st_d = ST_IDLE;
                    else if (char_in != CH_CR) bad = 1'b1;
                end
                ST_SKIP: if (char_in == CH_LF) st_d = ST_IDLE;
                ST_ERR:  st_d = ST_ERR;
                default: st_d = ST_IDLE;
            endcase
            if (bad) st_d = ST_ERR;
        end
    end

    // Datapath registers: no reset needed, always written before use.
    always_ff @(posedge clk) begin
        nib_hi_q  <= nib_hi_d;
        cnt_q     <= cnt_d;
        nib_idx_q <= nib_idx_d;
        addr_q    <= addr_d;
        if (wr_fire) begin
            wr_addr_q <= addr_q;
            wr_data_q <= byte_v;
        end
    end

    // Control registers: state, strobes and flags with a defined reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            wr_valid_q <= 1'b0;
            loading_q  <= 1'b0;
            err_q      <= 1'b0;
            err_line_q <= '0;
        end else begin
            st_q       <= st_d;
            wr_valid_q <= wr_fire;
            if (load_set)      loading_q <= 1'b1;
            else if (load_clr) loading_q <= 1'b0;
            if (bad) begin
                err_q      <= 1'b1;
                err_line_q <= line_cur;
            end
        end
    end

    assign wr_valid = wr_valid_q;
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;
    assign loading  = loading_q;
    assign err      = err_q;
    assign err_line = err_line_q;

    // R1: without a strobe nothing is written and the flags hold.
    a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |=> !wr_valid && $stable(loading) && $stable(err));

    // R5 / R3: writes only happen inside a load.
    a_r5_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> loading);

    // R8: the error flag and its line number stick.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && $stable(err_line));

    // R8: no write once an error is latched.
    a_r8_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !wr_valid);
endmodule

// File: tb/srec_loader_parser_tb_top.sv
// Self-checking bench: sweeps record lengths, addresses and all byte values,
// then drives each error class after varying numbers of line feeds.
module srec_loader_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_in = 8'h00;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        loading;
    logic        err;
    logic [15:0] err_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit exp_wr = 1'b0;
    logic [31:0] exp_a = '0;
    logic [7:0]  exp_d = '0;
    int line_no = 1;

    srec_loader_parser #(.ADDR_W(32), .LINE_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .loading(loading), .err(err), .err_line(err_line)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] v);
        return (v < 4'd10) ? 8'h30 + 8'(v) : 8'h37 + 8'(v);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        char_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        line_no = 1;
        exp_wr = 1'b0;
    endtask

    // One character, then one quiet cycle; write checks after each edge.
    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        char_valid = 1'b1;
        char_in = c;
        @(posedge clk); #1;
        chk(wr_valid == exp_wr, "R3 write strobe", 32'(wr_valid), 32'(exp_wr));
        if (exp_wr) begin
            chk(wr_addr == exp_a, "R3 write address", wr_addr, exp_a);
            chk(wr_data == exp_d, "R3 write data", 32'(wr_data), 32'(exp_d));
        end
        @(negedge clk);
        char_valid = 1'b0;
        char_in = 8'h00;
        @(posedge clk); #1;
        chk(wr_valid == 1'b0, "R1 no strobe no write", 32'(wr_valid), 0);
        exp_wr = 1'b0;
        if (c == 8'h0A) line_no++;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit wr, input logic [31:0] a);
        send_char(hexc(b[7:4]));
        exp_wr = wr;
        exp_a = a;
        exp_d = b;
        send_char(hexc(b[3:0]));
    endtask

    // Data record with n bytes d_i = seed + i*stride.
    task automatic send_s3(input logic [31:0] a, input int n, input logic [7:0] seed,
                           input logic [7:0] stride, input bit corrupt, input bit live);
        logic [7:0] sum;
        logic [7:0] cnt;
        logic [7:0] d;
        cnt = 8'(n + 5);
        sum = cnt + a[31:24] + a[23:16] + a[15:8] + a[7:0];
        send_char(8'h53);
        send_char(8'h33);
        if (live) chk(loading == 1'b1, "R5 loading rises on data record", 32'(loading), 1);
        send_byte(cnt, 1'b0, 0);
        for (int k = 3; k >= 0; k--) send_byte(a[k*8 +: 8], 1'b0, 0);
        for (int i = 0; i < n; i++) begin
            d = seed + 8'(i) * stride;
            sum = sum + d;
            send_byte(d, live, a + 32'(i));
        end
        send_byte(~sum ^ {7'd0, corrupt}, 1'b0, 0);
        send_str("\r\n");
        if (live && !corrupt) chk(err == 1'b0, "R7 good checksum accepted", 32'(err), 0);
    endtask

    initial begin
        do_reset();
        #1;
        chk(wr_valid == 1'b0, "R11 reset wr_valid", 32'(wr_valid), 0);
        chk(loading == 1'b0, "R11 reset loading", 32'(loading), 0);
        chk(err == 1'b0, "R11 reset err", 32'(err), 0);
        chk(err_line == 16'd0, "R11 reset err_line", 32'(err_line), 0);

        // R2: stray text while idle
        send_str("xyz#3\r\n");
        chk(err == 1'b0, "R2 idle text ignored err", 32'(err), 0);
        chk(loading == 1'b0, "R2 idle text ignored loading", 32'(loading), 0);

        // R10: header record skipped
        send_str("S00600004844521B\r\n");
        chk(err == 1'b0, "R10 skipped type no error", 32'(err), 0);
        chk(loading == 1'b0, "R10 skipped type no load", 32'(loading), 0);

        // R3 R6: length and address sweep, including address wrap
        for (int n = 0; n < 10; n++) begin
            send_s3(32'h1FC0_0000 + 32'(n * 64), n, 8'(n * 17), 8'd29, 1'b0, 1'b1);
            send_s3(32'hFFFF_FFFC, n, 8'(n), 8'd3, 1'b0, 1'b1);
        end
        // R4: every byte value once, covers every hex digit in both nibbles
        send_s3(32'h0000_1000, 128, 8'd0, 8'd1, 1'b0, 1'b1);
        send_s3(32'h0000_1080, 128, 8'd128, 8'd1, 1'b0, 1'b1);

        // R9: extra carriage returns after the checksum
        send_str("S30500000000FA\r\r\r\n");
        chk(err == 1'b0, "R9 carriage returns skipped", 32'(err), 0);

        // R5: end record drops loading
        send_str("S7");
        chk(loading == 1'b0, "R5 loading falls on end record", 32'(loading), 0);
        send_str("0500000000FA\r\n");
        chk(err == 1'b0, "R10 end record no error", 32'(err), 0);

        // R7 R8: bad checksum on line 3, then ignored input
        do_reset();
        send_str("\n\n");
        send_s3(32'h0000_0040, 3, 8'h5A, 8'd7, 1'b1, 1'b1);
        chk(err == 1'b1, "R7 bad checksum flagged", 32'(err), 1);
        chk(err_line == 16'd3, "R7 error line", 32'(err_line), 3);
        send_s3(32'h0000_0080, 4, 8'h11, 8'd5, 1'b0, 1'b0);
        chk(err == 1'b1, "R8 error sticky", 32'(err), 1);
        chk(err_line == 16'd3, "R8 error line held", 32'(err_line), 3);

        // R4: lowercase hex rejected on line 1
        do_reset();
        send_str("S3090000000a");
        chk(err == 1'b1, "R4 lowercase hex rejected", 32'(err), 1);
        chk(err_line == 16'd1, "R4 error line", 32'(err_line), 1);

        // R6: count below five rejected on line 2
        do_reset();
        send_str("junk\nS304");
        chk(err == 1'b1, "R6 short count rejected", 32'(err), 1);
        chk(err_line == 16'd2, "R6 error line", 32'(err_line), 2);

        // R9: stray text after checksum on line 5
        do_reset();
        send_str("\n\n\n\nS30500000000FA");
        chk(err == 1'b0, "R9 record ok before stray", 32'(err), 0);
        send_str("X");
        chk(err == 1'b1, "R9 stray after checksum", 32'(err), 1);
        chk(err_line == 16'd5, "R9 error line", 32'(err_line), 5);

        // R10: non-digit type rejected
        do_reset();
        send_str("S5030001FB\nSZ");
        chk(err == 1'b1, "R10 non-digit type rejected", 32'(err), 1);
        chk(err_line == 16'd2, "R10 error line", 32'(err_line), 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule